// File: doc/BRIEF.md
# Tree Up/Down Route Unit

This unit makes the routing decision for one switch of a k-ary tree or fat-tree of height DEPTH, where k = 2^K_LOG2. Every leaf address is DEPTH digits of K_LOG2 bits each, read from the root toward the leaf, with digit 0 in the least significant bits. For each valid header the unit does one of three things. It keeps climbing toward the lowest common ancestor of source and destination. It turns or continues downward toward a child port. Or it ejects the packet to the local port.

The turn height is one plus the index of the most significant non-zero digit of source XOR destination. The header carries a level counter and a down flag. The unit returns the updated counter, which is one higher after an up hop and one lower after a down hop.

When going down from height L, the child index is destination digit L-1. In fat-tree builds (PARENTS > 1), each up-routed packet takes the parent link named by a round-robin pointer, and the pointer then moves on. All results are registered and appear one cycle after the header.

Top module: `tree_route_unit`

## Requirements
- R1: After reset, out_valid_o is 0, and the first up-routed packet is given parent index 0.
- R2: out_valid_o equals hdr_valid_i from the previous cycle. The other outputs are meaningful only while out_valid_o is 1.
- R3: The result is an eject (out_eject_o=1, out_up_o=0, level unchanged) in two cases: down_i=0 with equal addresses, or down_i=1 with level 0.
- R4: Let the turn height T be 1 plus the index of the most significant non-zero K_LOG2-bit digit of src XOR dst. Digit j occupies bits [j*K_LOG2 +: K_LOG2], and all bits of a digit count toward that digit. When down_i=0, the addresses differ and level_i < T, the result is up (out_up_o=1) with out_level_o = level_i + 1.
- R5: When down_i=0, the addresses differ and level_i >= T, the result is down: out_up_o=0, out_eject_o=0, out_child_o = destination digit level_i-1, and out_level_o = level_i - 1.
- R6: When down_i=1 and level_i > 0, the result is down with child = destination digit level_i-1 and level_i-1, whatever the source address.
- R7: Up-routed valid packets receive parent indices 0, 1, …, PARENTS-1 and then wrap to 0. The pointer does not move on down results, eject results or invalid cycles.
- R8: out_parent_o is 0 on non-up results, and out_child_o is 0 on up and eject results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hdr_valid_i | input | 1 | Header present this cycle |
| src_addr_i | input | K_LOG2*DEPTH | Source leaf address |
| dst_addr_i | input | K_LOG2*DEPTH | Destination leaf address |
| level_i | input | clog2(DEPTH+1) | Header level counter (current height) |
| down_i | input | 1 | Packet already travelling downward |
| out_valid_o | output | 1 | Result valid |
| out_up_o | output | 1 | Route to a parent |
| out_eject_o | output | 1 | Deliver to local port |
| out_child_o | output | K_LOG2 | Child index for a down hop |
| out_parent_o | output | max(1,clog2(PARENTS)) | Parent link for an up hop |
| out_level_o | output | clog2(DEPTH+1) | Updated level counter |

## Verification
The bench builds the unit with K_LOG2=2 (4-ary), DEPTH=3 and PARENTS=3. Multi-bit digits make it possible to check that a difference spread over two bits of one digit still selects that digit. Three levels allow full climbs, turns at every height and complete descents down to eject. Three parents, a count that is not a power of two, exercise the round-robin wrap and its hold on non-up cycles, and a reset in mid-run shows the pointer restarting at zero.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;

  typedef enum logic [1:0] {
    RK_EJECT = 2'd0,
    RK_UP    = 2'd1,
    RK_DOWN  = 2'd2
  } route_kind_e;

  function automatic int unsigned w_min1(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tree_msd_find.sv
module tree_msd_find #(
  parameter int unsigned K_LOG2 = 1,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned IDX_W  = tree_route_pkg::w_min1(DEPTH)
) (
  input  logic [K_LOG2*DEPTH-1:0] diff_i,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o
);

  logic [DEPTH-1:0] digit_nz;

  for (genvar j = 0; j < DEPTH; j++) begin : g_nz
    assign digit_nz[j] = |diff_i[j*K_LOG2 +: K_LOG2];
  end

  always_comb begin
    idx_o = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (digit_nz[j]) idx_o = IDX_W'(j);
    end
  end

  assign any_o = |digit_nz;

  always_comb begin
    if (!any_o) a_r4_no_digit_no_diff : assert (diff_i == '0);
  end

endmodule

// File: rtl/tree_rr_ptr.sv
module tree_rr_ptr #(
  parameter int unsigned PARENTS = 2,
  parameter int unsigned PAR_W   = tree_route_pkg::w_min1(PARENTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PAR_W-1:0] ptr_o
);

  if (PARENTS > 1) begin : g_rr
    logic [PAR_W-1:0] ptr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ptr_q <= '0;
      else if (adv_i)  ptr_q <= (ptr_q == PAR_W'(PARENTS-1)) ? '0 : ptr_q + 1'b1;
    end

    assign ptr_o = ptr_q;

    a_r7_hold_when_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_i |=> $stable(ptr_o));
    a_r7_in_range : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptr_o <= PAR_W'(PARENTS-1));
  end else begin : g_single
    assign ptr_o = '0;
  end

endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit
  import tree_route_pkg::*;
#(
  parameter int unsigned K_LOG2  = 1,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned PARENTS = 1,
  localparam int unsigned ADDR_W = K_LOG2 * DEPTH,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
  localparam int unsigned PAR_W  = w_min1(PARENTS),
  localparam int unsigned IDX_W  = w_min1(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_valid_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              down_i,
  output logic              out_valid_o,
  output logic              out_up_o,
  output logic              out_eject_o,
  output logic [K_LOG2-1:0] out_child_o,
  output logic [PAR_W-1:0]  out_parent_o,
  output logic [LVL_W-1:0]  out_level_o
);

  logic              diff_any;
  logic [IDX_W-1:0]  diff_idx;
  logic [LVL_W-1:0]  turn_lvl;
  route_kind_e       kind;
  logic [K_LOG2-1:0] child_d;
  logic [LVL_W-1:0]  level_d;
  logic [PAR_W-1:0]  rr_ptr;

  tree_msd_find #(.K_LOG2(K_LOG2), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_msd (
    .diff_i (src_addr_i ^ dst_addr_i),
    .any_o  (diff_any),
    .idx_o  (diff_idx)
  );

  assign turn_lvl = diff_any ? LVL_W'(diff_idx) + LVL_W'(1) : '0;

  always_comb begin
    if (down_i)                kind = (level_i == '0) ? RK_EJECT : RK_DOWN;
    else if (!diff_any)        kind = RK_EJECT;
    else if (level_i < turn_lvl) kind = RK_UP;
    else                       kind = RK_DOWN;
  end

  // child port = destination digit one below current height
  always_comb begin
    child_d = '0;
    if (kind == RK_DOWN) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (level_i == LVL_W'(j + 1)) child_d = dst_addr_i[j*K_LOG2 +: K_LOG2];
      end
    end
  end

  always_comb begin
    unique case (kind)
      RK_UP:   level_d = level_i + LVL_W'(1);
      RK_DOWN: level_d = level_i - LVL_W'(1);
      default: level_d = level_i;
    endcase
  end

  tree_rr_ptr #(.PARENTS(PARENTS), .PAR_W(PAR_W)) u_rr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (hdr_valid_i && (kind == RK_UP)),
    .ptr_o  (rr_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_up_o     <= 1'b0;
      out_eject_o  <= 1'b0;
      out_child_o  <= '0;
      out_parent_o <= '0;
      out_level_o  <= '0;
    end else begin
      out_valid_o <= hdr_valid_i;
      if (hdr_valid_i) begin
        out_up_o     <= (kind == RK_UP);
        out_eject_o  <= (kind == RK_EJECT);
        out_child_o  <= child_d;
        out_parent_o <= (kind == RK_UP) ? rr_ptr : '0;
        out_level_o  <= level_d;
      end
    end
  end

  a_r2_valid_latency : assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(hdr_valid_i));
  a_r3_eject_not_up : assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_eject_o |-> !out_up_o && out_level_o == $past(level_i));
  a_r4_up_increments : assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_up_o |-> out_level_o == $past(level_i) + LVL_W'(1));
  a_r6_down_decrements : assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_up_o && !out_eject_o |-> out_level_o == $past(level_i) - LVL_W'(1));
  a_r8_field_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_up_o || out_parent_o == '0) && (!(out_up_o || out_eject_o) || out_child_o == '0));

endmodule

// File: tb/sim_tree_route_unit.sv
module sim_tree_route_unit;

  localparam int KL = 2;
  localparam int DP = 3;
  localparam int NP = 3;
  localparam int AW = KL * DP;
  localparam int LW = 2;
  localparam int PW = 2;

  typedef struct packed {
    logic          v;
    logic          up;
    logic          ej;
    logic [KL-1:0] ch;
    logic [PW-1:0] par;
    logic [LW-1:0] lvl;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          hdr_valid_i = 1'b0;
  logic [AW-1:0] src_addr_i = '0;
  logic [AW-1:0] dst_addr_i = '0;
  logic [LW-1:0] level_i = '0;
  logic          down_i = 1'b0;
  logic          out_valid_o, out_up_o, out_eject_o;
  logic [KL-1:0] out_child_o;
  logic [PW-1:0] out_parent_o;
  logic [LW-1:0] out_level_o;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;
  int    tb_rr = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  tree_route_unit #(.K_LOG2(KL), .DEPTH(DP), .PARENTS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hdr_valid_i(hdr_valid_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .level_i(level_i),
    .down_i(down_i), .out_valid_o(out_valid_o), .out_up_o(out_up_o),
    .out_eject_o(out_eject_o), .out_child_o(out_child_o),
    .out_parent_o(out_parent_o), .out_level_o(out_level_o)
  );

  function automatic exp_t model(input logic v, input logic [AW-1:0] s, d,
                                 input logic [LW-1:0] l, input logic dn);
    exp_t e;
    int t;
    int kind; // 0 eject 1 up 2 down
    e = '0;
    e.v = v;
    t = 0;
    for (int j = 0; j < DP; j++)
      if (((s ^ d) >> (j*KL)) & ((1 << KL) - 1)) t = j + 1;
    if (dn)          kind = (l == 0) ? 0 : 2;
    else if (t == 0) kind = 0;
    else if (l < t)  kind = 1;
    else             kind = 2;
    e.up = (kind == 1);
    e.ej = (kind == 0);
    e.lvl = (kind == 1) ? l + 1 : (kind == 2) ? l - 1 : l;
    if (kind == 2) e.ch = KL'(d >> ((int'(l) - 1) * KL));
    if (kind == 1) e.par = PW'(tb_rr);
    return e;
  endfunction

  task automatic send(input logic v, input logic [AW-1:0] s, d,
                      input logic [LW-1:0] l, input logic dn, input string tag);
    exp_t e;
    @(negedge clk);
    hdr_valid_i = v; src_addr_i = s; dst_addr_i = d; level_i = l; down_i = dn;
    e = model(v, s, d, l, dn);
    if (v && e.up) tb_rr = (tb_rr + 1) % NP;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        exp_t a;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        a = {out_valid_o, out_up_o, out_eject_o, out_child_o, out_parent_o, out_level_o};
        n_run++;
        if (!e.v) begin
          if (a.v !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: valid act=%b exp=0", tg, a.v);
          end
        end else if (a !== e) begin
          n_fail++;
          $display("FAIL %s: act v%b up%b ej%b ch%0d par%0d lvl%0d exp v%b up%b ej%b ch%0d par%0d lvl%0d",
                   tg, a.v, a.up, a.ej, a.ch, a.par, a.lvl, e.v, e.up, e.ej, e.ch, e.par, e.lvl);
        end
      end
    end
  end

  task automatic reset_check(input string tag);
    @(negedge clk);
    n_run++;
    if (out_valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: out_valid act=%b exp=0", tag, out_valid_o);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    reset_check("R1 reset state");
    // eject on equal addresses
    send(1, 6'h2D, 6'h2D, 2'd0, 0, "R3 equal addr");
    // T=1: up then turn to digit0
    send(1, 6'h00, 6'h01, 2'd0, 0, "R1 R4 first up parent0");
    send(1, 6'h00, 6'h01, 2'd1, 0, "R5 turn T1");
    // T=3: full climb with rr wrap
    send(1, 6'h00, 6'h30, 2'd0, 0, "R4 R7 climb L0");
    send(0, 6'h00, 6'h30, 2'd0, 0, "R2 R7 idle up-looking");
    send(1, 6'h00, 6'h30, 2'd1, 0, "R4 R7 climb L1");
    send(1, 6'h00, 6'h30, 2'd2, 0, "R4 R7 wrap climb L2");
    send(1, 6'h00, 6'h30, 2'd3, 0, "R5 turn at top");
    // descent to destination
    send(1, 6'h00, 6'h36, 2'd2, 1, "R6 down L2");
    send(1, 6'h00, 6'h36, 2'd1, 1, "R6 down L1");
    send(1, 6'h00, 6'h36, 2'd0, 1, "R3 down reach leaf");
    // digit grouping
    send(1, 6'h10, 6'h20, 2'd2, 0, "R4 two bits one digit");
    send(1, 6'h04, 6'h08, 2'd1, 0, "R4 digit1 climb");
    send(1, 6'h04, 6'h08, 2'd2, 0, "R5 turn child digit1");
    send(1, 6'h04, 6'h08, 2'd3, 0, "R5 above turn");
    // down ignores source
    send(1, 6'h1B, 6'h1B, 2'd3, 1, "R6 down src ignored");
    send(1, 6'h3F, 6'h2A, 2'd1, 1, "R6 R8 down digit0");
    send(1, 6'h11, 6'h13, 2'd0, 0, "R7 after holds");
    send(0, 6'h00, 6'h00, 2'd0, 0, "R2 idle");
    send(1, 6'h01, 6'h3F, 2'd0, 0, "R7 R8 next parent");
    @(negedge clk);
    hdr_valid_i = 0;
    wait (exp_q.size() == 0);
    // reset mid-run restarts pointer
    @(negedge clk);
    rst_ni = 1'b0;
    tb_rr = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    reset_check("R1 reset mid-run");
    send(1, 6'h00, 6'h20, 2'd0, 0, "R1 rr restart");
    send(1, 6'h00, 6'h20, 2'd1, 0, "R7 after reset");
    @(negedge clk);
    hdr_valid_i = 0;
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule